// File: doc/BRIEF.md
# Under-Frequency Stage with Arming and Abnormal-Frequency Supervision

This block is one definite-time under-frequency stage for a feeder protection relay, together with the supervision that decides when the stage may act. It receives a measured system frequency in units of 0.01 Hz, the three phase-to-phase voltage magnitudes and its settings: pickup frequency, voltage supervision level and trip delay in milliseconds. All timing is counted on a one-millisecond tick-enable pulse. Four such stages with independent settings make up a complete under-frequency function; each stage is one instance of this block.

The stage is live only while its enable setting and its enable input are both 1 and its block input is 0. Before a trip is possible the stage must arm. Arming needs the frequency to stay above the pickup level, with all three voltages above the supervision level, for 100 consecutive ticks. Once armed, a frequency below the pickup level that lasts for the set delay produces a trip. A frequency outside the 35.00 to 70.00 Hz window for 200 consecutive ticks blocks the stage until the frequency comes back inside the window. After that the stage must arm again from the start.

The control is a state machine with six states. OFF is held while the stage is disabled. QUALIFY counts the arming period. ARMED watches for low frequency. PICKUP counts the trip delay. TRIP holds the trip output. BLOCKED is held during abnormal frequency. The transitions are: OFF to QUALIFY on enable; QUALIFY to ARMED when the arming count completes; ARMED to PICKUP when the frequency falls below the pickup level; PICKUP to TRIP when the delay completes; PICKUP or TRIP back to ARMED when the frequency is at or above the pickup level; ARMED, PICKUP or TRIP to QUALIFY when a voltage is too low; any live state to BLOCKED when the abnormal-frequency count completes; BLOCKED to QUALIFY when the frequency is back inside the window; any state to OFF on disable.

Top module: `uf_stage_guard`

## Requirements
- R1: While the enable setting is 0, the enable input is 0 or the block input is 1, all three outputs are 0 two clocks later and stay 0. After the stage is enabled again, arming needs a full new count of 100 ticks.
- R2: With the frequency above the pickup level (the comparison is strict) and all three voltages above the supervision level (the comparison is strict), the armed output rises after the 100th consecutive tick. It is still 0 after 99 ticks.
- R3: If the frequency or any voltage fails its arming condition during qualification, the tick count restarts from zero.
- R4: While the stage is armed and the frequency is below the pickup level, the trip output rises after the number of ticks given by the delay setting. It is 0 one tick earlier. The armed output stays 1 while the trip output is 1.
- R5: If the frequency returns to or above the pickup level, the stage goes back to armed with trip 0, and the delay count restarts at the next drop.
- R6: Any voltage at or below the supervision level while the stage is armed clears both the armed and the trip outputs. Arming again needs a full new count of 100 ticks.
- R7: A frequency below 3500 (35.00 Hz) or above 7000 (70.00 Hz) for 200 consecutive ticks sets the blocked output and clears armed and trip. After 199 ticks the stage is not blocked.
- R8: When the frequency is back inside 3500..7000, the blocked output clears two clocks later, and arming needs a full new count of 100 ticks.
- R9: A blocked stage gives no trip, even while the frequency stays below the pickup level.
- R10: With a delay setting of 0, an armed stage trips two clocks after the frequency drops below the pickup level, without waiting for a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1ms | input | 1 | One-clock pulse once per millisecond |
| freq_in | input | 14 | Measured frequency, 0.01 Hz units |
| thr_in | input | 14 | Pickup frequency setting, 0.01 Hz units |
| v_ab | input | 16 | Phase-to-phase voltage A-B |
| v_bc | input | 16 | Phase-to-phase voltage B-C |
| v_ca | input | 16 | Phase-to-phase voltage C-A |
| vblk_in | input | 16 | Voltage supervision level |
| dly_in | input | 17 | Trip delay in milliseconds |
| en_set | input | 1 | Enable setting |
| en_bin | input | 1 | Enable binary input |
| blk_in | input | 1 | Block binary input |
| armed_o | output | 1 | Stage armed (ARMED, PICKUP or TRIP) |
| blocked_o | output | 1 | Stage blocked by abnormal frequency |
| trip_o | output | 1 | Trip output |

## Verification
Every counted result comes from a tick counter that is updated on the tick edge, followed by the state register one clock later. The bench therefore follows each tick pulse with three idle clocks and then samples at a falling edge, which places each count check exactly on the 99th/100th, 199th/200th or (delay-1)th/delay tick. Changes that need no tick, such as a voltage dip, disable, block release or a zero delay, act through the state register alone and settle within two clocks. The bench samples two falling edges after the input changes.

// File: rtl/uf_pkg.sv
package uf_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_QUALIFY,
        ST_ARMED,
        ST_PICKUP,
        ST_TRIP,
        ST_BLOCKED
    } uf_state_e;
endpackage

// File: rtl/uf_ms_timer.sv
module uf_ms_timer #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q >= limit);
endmodule

// File: rtl/uf_volt_ok.sv
module uf_volt_ok #(
    parameter int VOLT_W = 16,
    parameter int NPH    = 3
) (
    input  logic [NPH*VOLT_W-1:0] v_flat,
    input  logic [VOLT_W-1:0]     lim,
    output logic                  all_ok
);
    logic [NPH-1:0] above;

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        assign above[i] = v_flat[i*VOLT_W +: VOLT_W] > lim;
    end

    assign all_ok = &above;
endmodule

// File: rtl/uf_stage_guard.sv
module uf_stage_guard
    import uf_pkg::*;
#(
    parameter int FREQ_W = 14,
    parameter int VOLT_W = 16,
    parameter int DLY_W  = 17,
    parameter int ARM_MS = 100,
    parameter int BLK_MS = 200,
    parameter int F_LO   = 3500,
    parameter int F_HI   = 7000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1ms,
    input  logic [FREQ_W-1:0] freq_in,
    input  logic [FREQ_W-1:0] thr_in,
    input  logic [VOLT_W-1:0] v_ab,
    input  logic [VOLT_W-1:0] v_bc,
    input  logic [VOLT_W-1:0] v_ca,
    input  logic [VOLT_W-1:0] vblk_in,
    input  logic [DLY_W-1:0]  dly_in,
    input  logic              en_set,
    input  logic              en_bin,
    input  logic              blk_in,
    output logic              armed_o,
    output logic              blocked_o,
    output logic              trip_o
);
    localparam int NPH = 3;
    localparam logic [DLY_W-1:0]  ARM_LIM = DLY_W'(ARM_MS);
    localparam logic [DLY_W-1:0]  BLK_LIM = DLY_W'(BLK_MS);
    localparam logic [FREQ_W-1:0] LO_LIM  = FREQ_W'(F_LO);
    localparam logic [FREQ_W-1:0] HI_LIM  = FREQ_W'(F_HI);

    uf_state_e state_q, state_d;

    logic stage_en, volts_ok, abn_freq, f_above, f_below;
    logic arm_run, arm_done, dly_run, dly_done, abn_run, abn_done;

    assign stage_en = en_set && en_bin && !blk_in;
    assign abn_freq = (freq_in < LO_LIM) || (freq_in > HI_LIM);
    assign f_above  = freq_in > thr_in;
    assign f_below  = freq_in < thr_in;

    uf_volt_ok #(.VOLT_W(VOLT_W), .NPH(NPH)) u_volt (
        .v_flat (({v_ca, v_bc, v_ab})),
        .lim    (vblk_in),
        .all_ok (volts_ok)
    );

    assign arm_run = stage_en && (state_q == ST_QUALIFY) && f_above && volts_ok && !abn_freq;
    assign dly_run = stage_en && (state_q == ST_PICKUP) && f_below;
    assign abn_run = stage_en && abn_freq;

    uf_ms_timer #(.CW(DLY_W)) u_arm_tmr (
        .clk (clk), .rst_n (rst_n), .run (arm_run), .tick (tick_1ms),
        .limit (ARM_LIM), .done (arm_done)
    );

    uf_ms_timer #(.CW(DLY_W)) u_dly_tmr (
        .clk (clk), .rst_n (rst_n), .run (dly_run), .tick (tick_1ms),
        .limit (dly_in), .done (dly_done)
    );

    uf_ms_timer #(.CW(DLY_W)) u_abn_tmr (
        .clk (clk), .rst_n (rst_n), .run (abn_run), .tick (tick_1ms),
        .limit (BLK_LIM), .done (abn_done)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (!stage_en) begin
            state_d = ST_OFF;
        end else if (abn_done && (state_q != ST_OFF)) begin
            state_d = ST_BLOCKED;
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = ST_QUALIFY;
                ST_QUALIFY: if (arm_done) state_d = ST_ARMED;
                ST_ARMED: begin
                    if (!volts_ok)    state_d = ST_QUALIFY;
                    else if (f_below) state_d = ST_PICKUP;
                end
                ST_PICKUP: begin
                    if (!volts_ok)     state_d = ST_QUALIFY;
                    else if (!f_below) state_d = ST_ARMED;
                    else if (dly_done) state_d = ST_TRIP;
                end
                ST_TRIP: begin
                    if (!volts_ok)     state_d = ST_QUALIFY;
                    else if (!f_below) state_d = ST_ARMED;
                end
                ST_BLOCKED: if (!abn_freq) state_d = ST_QUALIFY;
                default:    state_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Outputs decoded from the state register
    always_comb begin
        armed_o   = 1'b0;
        blocked_o = 1'b0;
        trip_o    = 1'b0;
        unique case (state_q)
            ST_ARMED, ST_PICKUP: armed_o = 1'b1;
            ST_TRIP: begin
                armed_o = 1'b1;
                trip_o  = 1'b1;
            end
            ST_BLOCKED: blocked_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/uf_stage_guard_chk.sv
module uf_stage_guard_chk #(
    parameter int FREQ_W = 14,
    parameter int VOLT_W = 16,
    parameter int F_LO   = 3500,
    parameter int F_HI   = 7000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FREQ_W-1:0] freq_in,
    input logic [FREQ_W-1:0] thr_in,
    input logic [VOLT_W-1:0] v_ab,
    input logic [VOLT_W-1:0] v_bc,
    input logic [VOLT_W-1:0] v_ca,
    input logic [VOLT_W-1:0] vblk_in,
    input logic              en_set,
    input logic              en_bin,
    input logic              blk_in,
    input logic              armed_o,
    input logic              blocked_o,
    input logic              trip_o
);
    a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_set || !en_bin || blk_in) |=> (!armed_o && !trip_o && !blocked_o));

    a_r2_arm_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_o) |-> $past((freq_in > thr_in) && (v_ab > vblk_in) &&
                                 (v_bc > vblk_in) && (v_ca > vblk_in)));

    a_r4_trip_while_armed: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |-> armed_o);

    a_r4_trip_on_low_freq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_o) |-> $past(freq_in < thr_in));

    a_r7_block_on_abnormal: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blocked_o) |-> $past((freq_in < FREQ_W'(F_LO)) || (freq_in > FREQ_W'(F_HI))));

    a_r9_blocked_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_o |-> (!trip_o && !armed_o));
endmodule

bind uf_stage_guard uf_stage_guard_chk #(
    .FREQ_W (FREQ_W), .VOLT_W (VOLT_W), .F_LO (F_LO), .F_HI (F_HI)
) u_chk (
    .clk (clk), .rst_n (rst_n), .freq_in (freq_in), .thr_in (thr_in),
    .v_ab (v_ab), .v_bc (v_bc), .v_ca (v_ca), .vblk_in (vblk_in),
    .en_set (en_set), .en_bin (en_bin), .blk_in (blk_in),
    .armed_o (armed_o), .blocked_o (blocked_o), .trip_o (trip_o)
);

// File: tb/uf_stage_guard_test.sv
module uf_stage_guard_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1ms = 1'b0;
    logic [13:0] freq_in = 14'd5000;
    logic [13:0] thr_in = 14'd4950;
    logic [15:0] v_ab = 16'd100, v_bc = 16'd100, v_ca = 16'd100;
    logic [15:0] vblk_in = 16'd80;
    logic [16:0] dly_in = 17'd50;
    logic        en_set = 1'b1, en_bin = 1'b1, blk_in = 1'b0;
    logic        armed_o, blocked_o, trip_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_P/2) clk = ~clk;

    uf_stage_guard uut (
        .clk (clk), .rst_n (rst_n), .tick_1ms (tick_1ms),
        .freq_in (freq_in), .thr_in (thr_in),
        .v_ab (v_ab), .v_bc (v_bc), .v_ca (v_ca), .vblk_in (vblk_in),
        .dly_in (dly_in), .en_set (en_set), .en_bin (en_bin), .blk_in (blk_in),
        .armed_o (armed_o), .blocked_o (blocked_o), .trip_o (trip_o)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: {armed,blocked,trip} actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [2:0] outs();
        return {armed_o, blocked_o, trip_o};
    endfunction

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_1ms = 1'b1;
            @(negedge clk) tick_1ms = 1'b0;
            clocks(3);
        end
    endtask

    task automatic nominal();
        freq_in = 14'd5000; thr_in = 14'd4950;
        v_ab = 16'd100; v_bc = 16'd100; v_ca = 16'd100; vblk_in = 16'd80;
        en_set = 1'b1; en_bin = 1'b1; blk_in = 1'b0;
    endtask

    // Restart from OFF and arm with nominal inputs
    task automatic fresh_arm();
        @(negedge clk) en_set = 1'b0;
        clocks(2);
        nominal();
        clocks(2);
        ticks(100);
    endtask

    task automatic t_reset();
        clocks(2);
        check("R1 reset", outs(), 3'b000);
        @(negedge clk) rst_n = 1'b1;
        clocks(2);
        check("R1 after reset", outs(), 3'b000);
    endtask

    task automatic t_arm_basic();
        nominal();
        clocks(2);
        ticks(99);
        check("R2 99 ticks", outs(), 3'b000);
        ticks(1);
        check("R2 100 ticks", outs(), 3'b100);
    endtask

    task automatic t_disable();
        @(negedge clk) blk_in = 1'b1;
        clocks(2);
        check("R1 block input", outs(), 3'b000);
        ticks(120);
        check("R1 block held", outs(), 3'b000);
        @(negedge clk) blk_in = 1'b0;
        clocks(2);
        ticks(99);
        check("R1 rearm 99", outs(), 3'b000);
        ticks(1);
        check("R1 rearm 100", outs(), 3'b100);
        @(negedge clk) en_bin = 1'b0;
        clocks(2);
        check("R1 enable input low", outs(), 3'b000);
        en_bin = 1'b1;
    endtask

    task automatic t_qual_restart();
        @(negedge clk) en_set = 1'b0;
        clocks(2);
        nominal();
        clocks(2);
        ticks(60);
        @(negedge clk) v_bc = 16'd80;
        clocks(2);
        @(negedge clk) v_bc = 16'd100;
        ticks(60);
        check("R3 voltage interruption", outs(), 3'b000);
        ticks(40);
        check("R3 full recount", outs(), 3'b100);
        @(negedge clk) en_set = 1'b0;
        clocks(2);
        nominal();
        clocks(2);
        ticks(50);
        @(negedge clk) freq_in = 14'd4950;
        ticks(1);
        @(negedge clk) freq_in = 14'd5000;
        ticks(99);
        check("R3 frequency at threshold", outs(), 3'b000);
        ticks(1);
        check("R3 recount after freq", outs(), 3'b100);
    endtask

    task automatic t_trip_delay();
        fresh_arm();
        dly_in = 17'd50;
        @(negedge clk) freq_in = 14'd4900;
        clocks(2);
        ticks(49);
        check("R4 delay-1", outs(), 3'b100);
        ticks(1);
        check("R4 delay reached", outs(), 3'b101);
    endtask

    task automatic t_recover();
        @(negedge clk) freq_in = 14'd5000;
        clocks(2);
        check("R5 trip clears on recovery", outs(), 3'b100);
        @(negedge clk) freq_in = 14'd4900;
        clocks(2);
        ticks(30);
        @(negedge clk) freq_in = 14'd4950;
        clocks(2);
        check("R5 recovery before delay", outs(), 3'b100);
        @(negedge clk) freq_in = 14'd4900;
        clocks(2);
        ticks(49);
        check("R5 delay restarted", outs(), 3'b100);
        ticks(1);
        check("R5 trip after restart", outs(), 3'b101);
    endtask

    task automatic t_volt_dip();
        @(negedge clk) v_ca = 16'd80;
        clocks(2);
        check("R6 dip disarms", outs(), 3'b000);
        @(negedge clk) begin v_ca = 16'd100; freq_in = 14'd5000; end
        clocks(2);
        ticks(99);
        check("R6 rearm 99", outs(), 3'b000);
        ticks(1);
        check("R6 rearm 100", outs(), 3'b100);
    endtask

    task automatic t_abn_block();
        @(negedge clk) freq_in = 14'd7001;
        clocks(2);
        ticks(199);
        check("R7 199 ticks", outs(), 3'b100);
        ticks(1);
        check("R7 200 ticks", outs(), 3'b010);
        @(negedge clk) freq_in = 14'd7000;
        clocks(2);
        check("R8 release", outs(), 3'b000);
        ticks(99);
        check("R8 rearm 99", outs(), 3'b000);
        ticks(1);
        check("R8 rearm 100", outs(), 3'b100);
    endtask

    task automatic t_block_precedence();
        dly_in = 17'd500;
        @(negedge clk) freq_in = 14'd3499;
        clocks(2);
        ticks(199);
        check("R9 pickup before block", outs(), 3'b100);
        ticks(1);
        check("R9 blocked", outs(), 3'b010);
        ticks(400);
        check("R9 no trip while blocked", outs(), 3'b010);
        @(negedge clk) freq_in = 14'd3500;
        clocks(2);
        check("R8 release at lower edge", outs(), 3'b000);
    endtask

    task automatic t_zero_delay();
        fresh_arm();
        dly_in = 17'd0;
        @(negedge clk) freq_in = 14'd4949;
        @(negedge clk);
        check("R10 one clock", outs(), 3'b100);
        @(negedge clk);
        check("R10 two clocks", outs(), 3'b101);
    endtask

    initial begin
        t_reset();
        t_arm_basic();
        t_disable();
        t_qual_restart();
        t_trip_delay();
        t_recover();
        t_volt_dip();
        t_abn_block();
        t_block_precedence();
        t_zero_delay();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule